// File: doc/BRIEF.md
# Direct-Mapped Page Translation Buffer

This block keeps recently used page translations for one access side (instruction fetch or data) so that most accesses skip the hashed page table walk. It has 64 entries and is direct mapped: the low six bits of the 16-bit page index inside the effective address pick the entry. An entry matches only when both its stored virtual segment ID and its full stored page index equal those of the current access. The segment ID arrives from the segment stage together with the segment's two protection keys and its no-execute flag.

A lookup is combinational. It reports exactly one outcome: a hit (with the real address), a miss (the external walker must fetch the entry and load it through the fill port), a protection fault, or a no-execute fault. The fields of the selected entry (protection bits, changed flag and the stored address of the second page table word) are always visible. When a permitted data write hits an entry whose changed flag is clear, the block raises a changed-bit request for one cycle. The real address to update is on `ent_pte1_addr` during that cycle. The block marks its own copy as changed at the next edge, so the request is not raised again. Invalidation writes the all-ones value into the segment ID tag, either for one entry or for all 64 entries in one cycle. Because of this, the all-ones segment ID is reserved and never hits.

Top module: `page_xlate_buf`

## Requirements
- R1: A lookup hits only if the entry at index `lk_ea[17:12]` holds a segment ID equal to `lk_vsid` and a page index equal to `lk_ea[27:12]`. Otherwise it reports a miss, including when a different page index aliases to the same entry.
- R2: On a hit, `real_addr` is the stored 20-bit real page number followed by `lk_ea[11:0]`.
- R3: The key is `lk_key_prob` when `lk_problem` is 1, and `lk_key_sup` otherwise. With key 0, every access is allowed except a write (`lk_kind`=1) to a page whose protection bits are 11.
- R4: With key 1, protection bits 00 deny every access, 01 and 11 allow only reads (`lk_kind`=0) and fetches (`lk_kind`=2), and 10 allow everything. A denied access that matches the tag reports `prot_fault`.
- R5: A fetch with `lk_noexec` set reports `nx_fault` whatever the buffer holds. `lk_noexec` has no effect on reads and writes.
- R6: A permitted write hit to an entry with a clear changed flag raises `chg_req` in that cycle. The entry's changed flag reads 1 from the next cycle on, so `chg_req` does not repeat. Misses, faults and entries that are already changed never raise `chg_req`.
- R7: A pulse on `inv_one` makes the entry at index `inv_sel` miss from the next cycle on, and leaves the other entries unchanged.
- R8: A pulse on `inv_all` makes every entry miss from the next cycle on.
- R9: After reset every lookup misses.
- R10: With `lk_valid` high exactly one of `hit`, `miss`, `prot_fault`, `nx_fault` is 1. With `lk_valid` low all four are 0.
- R11: A lookup whose `lk_vsid` is all ones always misses.
- R12: In the same cycle, `inv_all` overrides everything, and `inv_one` overrides a fill to the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup present |
| lk_ea | input | 28 | Page index (27:12) and byte offset (11:0) |
| lk_vsid | input | 24 | Virtual segment ID from the segment stage |
| lk_kind | input | 2 | 0 read, 1 write, 2 fetch (3 treated as read) |
| lk_problem | input | 1 | Current state is problem (user) state |
| lk_key_sup | input | 1 | Segment key for supervisor state |
| lk_key_prob | input | 1 | Segment key for problem state |
| lk_noexec | input | 1 | Segment forbids instruction fetch |
| hit | output | 1 | Translation found and permitted |
| miss | output | 1 | No matching entry |
| prot_fault | output | 1 | Matching entry, access denied |
| nx_fault | output | 1 | Fetch from a no-execute segment |
| real_addr | output | 32 | Translated real address |
| ent_pp | output | 2 | Protection bits of the selected entry |
| ent_chg | output | 1 | Changed flag of the selected entry |
| ent_pte1_addr | output | 32 | Stored address of the second page table word |
| chg_req | output | 1 | Request to set the changed bit at ent_pte1_addr |
| fill_en | input | 1 | Load an entry |
| fill_pi | input | 16 | Page index of the new entry |
| fill_vsid | input | 24 | Segment ID of the new entry |
| fill_pp | input | 2 | Protection bits |
| fill_chg | input | 1 | Changed flag |
| fill_rpn | input | 20 | Real page number |
| fill_pte1_addr | input | 32 | Address of the second page table word |
| inv_one | input | 1 | Invalidate one entry |
| inv_sel | input | 6 | Index of the entry to invalidate |
| inv_all | input | 1 | Invalidate all entries |

## Verification
A corrupted tag shows up at the ports in the same cycle the entry is looked up. It appears either as a miss where the bench expects a hit, or as a false hit after an alias or an invalidation. A wrong copy of the changed flag shows one cycle after a write, as a repeated or missing `chg_req`. Protection-table errors appear in the very cycle of the access, as a swapped hit and fault. Therefore every check samples the combinational outcome in the cycle of the lookup, and samples once more one edge later wherever stored state should have moved.

// File: rtl/page_xlate_buf.sv
module page_xlate_buf #(
  parameter int OFF_W  = 12,
  parameter int PI_W   = 16,
  parameter int IDX_W  = 6,
  parameter int VSID_W = 24,
  parameter int RPN_W  = 20,
  parameter int PTEA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [PI_W+OFF_W-1:0]  lk_ea,
  input  logic [VSID_W-1:0]      lk_vsid,
  input  logic [1:0]             lk_kind,
  input  logic                   lk_problem,
  input  logic                   lk_key_sup,
  input  logic                   lk_key_prob,
  input  logic                   lk_noexec,
  output logic                   hit,
  output logic                   miss,
  output logic                   prot_fault,
  output logic                   nx_fault,
  output logic [RPN_W+OFF_W-1:0] real_addr,
  output logic [1:0]             ent_pp,
  output logic                   ent_chg,
  output logic [PTEA_W-1:0]      ent_pte1_addr,
  output logic                   chg_req,
  input  logic                   fill_en,
  input  logic [PI_W-1:0]        fill_pi,
  input  logic [VSID_W-1:0]      fill_vsid,
  input  logic [1:0]             fill_pp,
  input  logic                   fill_chg,
  input  logic [RPN_W-1:0]       fill_rpn,
  input  logic [PTEA_W-1:0]      fill_pte1_addr,
  input  logic                   inv_one,
  input  logic [IDX_W-1:0]       inv_sel,
  input  logic                   inv_all
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [1:0] K_WRITE = 2'd1;
  localparam logic [1:0] K_FETCH = 2'd2;

  logic [VSID_W-1:0] tag_vsid [ENTRIES];
  logic [PI_W-1:0]   tag_pi   [ENTRIES];
  logic [1:0]        e_pp     [ENTRIES];
  logic              e_chg    [ENTRIES];
  logic [RPN_W-1:0]  e_rpn    [ENTRIES];
  logic [PTEA_W-1:0] e_pte1   [ENTRIES];

  wire [PI_W-1:0]  lk_pi    = lk_ea[OFF_W +: PI_W];
  wire [IDX_W-1:0] lk_idx   = lk_pi[IDX_W-1:0];
  wire [IDX_W-1:0] fill_idx = fill_pi[IDX_W-1:0];

  wire tag_match = (tag_vsid[lk_idx] == lk_vsid) && (tag_pi[lk_idx] == lk_pi)
                   && (lk_vsid != {VSID_W{1'b1}});
  wire key       = lk_problem ? lk_key_prob : lk_key_sup;
  wire is_write  = (lk_kind == K_WRITE);
  wire is_fetch  = (lk_kind == K_FETCH);
  wire [1:0] pp  = e_pp[lk_idx];

  logic allow;
  always_comb begin
    if (!key)
      allow = !(is_write && pp == 2'b11);
    else
      case (pp)
        2'b00:   allow = 1'b0;
        2'b10:   allow = 1'b1;
        default: allow = !is_write;
      endcase
  end

  assign nx_fault      = lk_valid && is_fetch && lk_noexec;
  assign miss          = lk_valid && !nx_fault && !tag_match;
  assign hit           = lk_valid && !nx_fault && tag_match && allow;
  assign prot_fault    = lk_valid && !nx_fault && tag_match && !allow;
  assign real_addr     = {e_rpn[lk_idx], lk_ea[OFF_W-1:0]};
  assign ent_pp        = pp;
  assign ent_chg       = e_chg[lk_idx];
  assign ent_pte1_addr = e_pte1[lk_idx];
  assign chg_req       = hit && is_write && !e_chg[lk_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_vsid[i] <= '1;
        tag_pi[i]   <= '0;
        e_pp[i]     <= '0;
        e_chg[i]    <= 1'b0;
        e_rpn[i]    <= '0;
        e_pte1[i]   <= '0;
      end
    end else begin
      if (chg_req) e_chg[lk_idx] <= 1'b1;
      if (fill_en) begin
        tag_vsid[fill_idx] <= fill_vsid;
        tag_pi[fill_idx]   <= fill_pi;
        e_pp[fill_idx]     <= fill_pp;
        e_chg[fill_idx]    <= fill_chg;
        e_rpn[fill_idx]    <= fill_rpn;
        e_pte1[fill_idx]   <= fill_pte1_addr;
      end
      if (inv_one) tag_vsid[inv_sel] <= '1;
      if (inv_all)
        for (int i = 0; i < ENTRIES; i++) tag_vsid[i] <= '1;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot({hit, miss, prot_fault, nx_fault})); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(hit || miss || prot_fault || nx_fault)); // R10
  AST_NO_REQ_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (miss || prot_fault || nx_fault) |-> !chg_req); // R6
  AST_REQ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_req && !fill_en) |=> !(chg_req && $stable(lk_ea) && $stable(lk_vsid))); // R6
  AST_INV_ONE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_one |=> !((hit || prot_fault) && lk_idx == $past(inv_sel))); // R7
  AST_INV_ALL_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !(hit || prot_fault)); // R8
endmodule

// File: tb/page_xlate_buf_bench.sv
module page_xlate_buf_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, lk_valid, lk_problem, lk_key_sup, lk_key_prob, lk_noexec;
  logic [27:0] lk_ea;
  logic [23:0] lk_vsid;
  logic [1:0]  lk_kind;
  logic        hit, miss, prot_fault, nx_fault, ent_chg, chg_req;
  logic [31:0] real_addr, ent_pte1_addr;
  logic [1:0]  ent_pp;
  logic        fill_en, fill_chg, inv_one, inv_all;
  logic [15:0] fill_pi;
  logic [23:0] fill_vsid;
  logic [1:0]  fill_pp;
  logic [19:0] fill_rpn;
  logic [31:0] fill_pte1_addr;
  logic [5:0]  inv_sel;

  page_xlate_buf u_page_xlate_buf (.*);

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] outcome();
    case ({nx_fault, prot_fault, miss, hit})
      4'b0000: return 3'd0;
      4'b0001: return 3'd1;
      4'b0010: return 3'd2;
      4'b0100: return 3'd3;
      4'b1000: return 3'd4;
      default: return 3'd7;
    endcase
  endfunction

  task automatic look(input logic [27:0] ea, input logic [23:0] vs, input logic [1:0] kd,
                      input logic pr, input logic ks, input logic kp, input logic nx);
    @(negedge clk);
    lk_valid = 1'b1; lk_ea = ea; lk_vsid = vs; lk_kind = kd;
    lk_problem = pr; lk_key_sup = ks; lk_key_prob = kp; lk_noexec = nx;
    #2;
  endtask

  task automatic fill(input logic [15:0] pi, input logic [23:0] vs, input logic [1:0] pp,
                      input logic c, input logic [19:0] rpn, input logic [31:0] pa);
    @(negedge clk);
    fill_en = 1'b1; fill_pi = pi; fill_vsid = vs; fill_pp = pp;
    fill_chg = c; fill_rpn = rpn; fill_pte1_addr = pa;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  localparam logic [23:0] VA = 24'h0ABCDE, VB = 24'h000111, VC = 24'h000222, VD = 24'h000333;
  localparam logic [27:0] EA_A = 28'h1234ABC, EA_B = 28'h00070FF, EA_C = 28'h0A01010, EA_D = 28'h0042444;

  // {valid, ea, vsid, kind, problem, key_sup, key_prob, noexec, outcome, real_addr}
  localparam int NV = 16;
  localparam logic [93:0] VEC [NV] = '{
    {1'b1, EA_A, VA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 32'h5555_5ABC},
    {1'b1, EA_A, VA, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1, 32'h5555_5ABC},
    {1'b1, EA_B, VB, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 32'h0},
    {1'b1, EA_B, VB, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1, 32'h1234_50FF},
    {1'b1, EA_B, VB, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd3, 32'h0},
    {1'b1, EA_C, VC, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd3, 32'h0},
    {1'b1, EA_C, VC, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd1, 32'h00AB_C010},
    {1'b1, EA_D, VD, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 32'h0F00_F444},
    {1'b1, EA_D, VD, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd3, 32'h0},
    {1'b1, EA_D, VD, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1, 32'h0F00_F444},
    {1'b1, EA_A, 24'h0ABCDF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 32'h0},
    {1'b1, 28'h5634000, VA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 32'h0},
    {1'b1, EA_A, VA, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4, 32'h0},
    {1'b1, EA_A, VA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 32'h5555_5ABC},
    {1'b0, EA_A, VA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h0},
    {1'b1, 28'h0, 24'hFFFFFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 32'h0}
  };
  localparam string RTAG [NV] = '{"R1 R2 R3", "R4", "R3", "R4 R2", "R4", "R4", "R3",
                                  "R3 R6", "R4", "R4", "R1", "R1", "R5", "R5", "R10", "R11"};

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_ea = '0; lk_vsid = '0; lk_kind = '0;
    lk_problem = 1'b0; lk_key_sup = 1'b0; lk_key_prob = 1'b0; lk_noexec = 1'b0;
    fill_en = 1'b0; fill_pi = '0; fill_vsid = '0; fill_pp = '0; fill_chg = 1'b0;
    fill_rpn = '0; fill_pte1_addr = '0; inv_one = 1'b0; inv_sel = '0; inv_all = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    #2 chk("R10 idle outcome", 32'(outcome()), 32'd0);
    look(EA_A, VA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 reset miss", 32'(outcome()), 32'd2);
    look(28'h0, 24'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 reset miss idx0", 32'(outcome()), 32'd2);

    fill(16'h1234, VA, 2'b10, 1'b0, 20'h55555, 32'h0000_1008);
    fill(16'h0007, VB, 2'b11, 1'b1, 20'h12345, 32'h0000_2000);
    fill(16'h0A01, VC, 2'b00, 1'b0, 20'h00ABC, 32'h0000_3000);
    fill(16'h0042, VD, 2'b01, 1'b1, 20'h0F00F, 32'h0000_4000);

    for (int i = 0; i < NV; i++) begin
      logic [93:0] v;
      v = VEC[i];
      look(v[92:65], v[64:41], v[40:39], v[38], v[37], v[36], v[35]);
      lk_valid = v[93];
      #1;
      chk($sformatf("row %0d %s outcome", i, RTAG[i]), 32'(outcome()), 32'(v[34:32]));
      if (v[34:32] == 3'd1)
        chk($sformatf("row %0d R2 real_addr", i), real_addr, v[31:0]);
      chk($sformatf("row %0d R6 chg_req", i), 32'(chg_req), 32'd0);
    end

    look(EA_A, VA, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6 first write hit", 32'(outcome()), 32'd1);
    chk("R6 request raised", 32'(chg_req), 32'd1);
    chk("R6 request address", ent_pte1_addr, 32'h0000_1008);
    chk("R6 flag before", 32'(ent_chg), 32'd0);
    @(negedge clk); #2;
    chk("R6 request not repeated", 32'(chg_req), 32'd0);
    chk("R6 flag after", 32'(ent_chg), 32'd1);

    @(negedge clk);
    lk_valid = 1'b0; inv_one = 1'b1; inv_sel = 6'h07;
    @(negedge clk);
    inv_one = 1'b0;
    look(EA_B, VB, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 invalidated entry misses", 32'(outcome()), 32'd2);
    look(EA_A, VA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7 other entry still hits", 32'(outcome()), 32'd1);

    @(negedge clk);
    lk_valid = 1'b0;
    fill_en = 1'b1; fill_pi = 16'h0010; fill_vsid = 24'h000444; fill_pp = 2'b10;
    fill_chg = 1'b1; fill_rpn = 20'h00777; fill_pte1_addr = 32'h5000;
    inv_one = 1'b1; inv_sel = 6'h10;
    @(negedge clk);
    fill_en = 1'b0; inv_one = 1'b0;
    look(28'h0010123, 24'h000444, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R12 inv_one beats fill", 32'(outcome()), 32'd2);
    fill(16'h0010, 24'h000444, 2'b10, 1'b1, 20'h00777, 32'h5000);
    look(28'h0010123, 24'h000444, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R1 refill hits", 32'(outcome()), 32'd1);
    chk("R2 refill real_addr", real_addr, 32'h0077_7123);

    @(negedge clk);
    lk_valid = 1'b0;
    fill_en = 1'b1; fill_pi = 16'h0020; fill_vsid = 24'h000555; fill_pp = 2'b10;
    fill_chg = 1'b0; fill_rpn = 20'h00888; fill_pte1_addr = 32'h6000;
    inv_all = 1'b1;
    @(negedge clk);
    fill_en = 1'b0; inv_all = 1'b0;
    look(28'h0020000, 24'h000555, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R12 inv_all beats fill", 32'(outcome()), 32'd2);
    look(EA_A, VA, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 entry A cleared", 32'(outcome()), 32'd2);
    look(EA_D, VD, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 entry D cleared", 32'(outcome()), 32'd2);
    look(EA_C, VC, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R8 entry C cleared", 32'(outcome()), 32'd2);

    @(negedge clk);
    lk_valid = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule